// File: doc/BRIEF.md
# Vector Element Byte Load Unit

This unit carries out one indexed single-byte load into a 128-bit vector register. It takes a 32-bit instruction word through a valid/ready handshake and checks that the word is the byte-element load. It then reads a base and an index from two general-purpose register read ports and forms the effective address. It sends a one-byte read to memory and waits for the response byte.

The unit places the returned byte into one lane of the destination vector. The lane is picked by the low four address bits. The other fifteen lanes keep the prior contents that the unit reads through a vector read port. The merged vector goes out on a one-cycle write port, and a completion pulse carries a program-counter step of 4. A word that does not decode is rejected with a one-cycle illegal flag. A rejected word causes no memory traffic and no register write.

Register numbering follows the big-endian convention: word bit 31 is instruction bit 0. Vector lane 0 is the most significant byte.

Top module: `vbyte_load_unit`

## Requirements
- R1: A word is legal only when word bits 31:26 equal 31, word bits 10:1 equal 7 and word bit 0 (the record flag) is 0.
- R2: The destination vector number is taken from word bits 25:21, the base register number from bits 20:16 and the index register number from bits 15:11. The base and index numbers drive `gpr_a_idx` and `gpr_b_idx` in the cycle after acceptance, and the destination number drives `vec_wr_idx` during the write.
- R3: When the base register number is 0, the base is the constant zero and the value on `gpr_a_data` is ignored.
- R4: The memory address is the low 32 bits of the 64-bit wrapping sum of base and index. It is issued unaligned, starting two cycles after acceptance.
- R5: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen high. The request drops in the cycle after it is accepted.
- R6: The returned byte lands in lane EA[3:0], where lane k occupies vector bits 127-8k down to 120-8k.
- R7: Every other lane of `vec_wr_data` equals the same lane of `vec_rd_data`.
- R8: `vec_we` and `done` are high for exactly one cycle, in the cycle after `mem_rsp_valid`. `pc_step` equals 4 in that cycle and 0 otherwise.
- R9: An illegal word raises `illegal` for exactly one cycle, in the cycle after acceptance. It issues no memory request and no vector write, and the unit is idle again in the next cycle.
- R10: `insn_ready` is high only when the unit is idle. A word presented while a load is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Unit idle, word accepted this cycle |
| gpr_a_idx | output | 5 | Base register read index |
| gpr_a_data | input | 64 | Base register value |
| gpr_b_idx | output | 5 | Index register read index |
| gpr_b_data | input | 64 | Index register value |
| vec_rd_idx | output | 5 | Destination vector read index (prior value) |
| vec_rd_data | input | 128 | Prior destination vector |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Response byte present |
| mem_rsp_data | input | 8 | Response byte |
| vec_we | output | 1 | Vector write enable |
| vec_wr_idx | output | 5 | Vector write index |
| vec_wr_data | output | 128 | Merged vector |
| illegal | output | 1 | Undecodable word rejected |
| done | output | 1 | Load completed |
| pc_step | output | 3 | Program-counter increment at completion |

## Verification
The bench sets a nonzero value in register 0 and loads through base number 0. A design that reads the register instead of using zero would issue the wrong address. It forms a base-plus-index sum that carries past bit 63 and another whose upper word is nonzero. A design that truncated before adding, or aligned the address, would show a wrong `mem_req_addr` or lane. It hits lanes 0, 3, 8 and 15 with distinctive prior vectors. A mirrored lane order or a clobbered neighbour shows up as a mismatch outside the target byte. It stalls the request and the response and offers a word while busy, which exposes a request that drifts, a write that fires early or twice, and a unit that accepts a second word. It also sends words with a wrong primary opcode, a wrong extended opcode and a set record flag. A decoder that misses any of these would touch memory.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

  // Instruction format constants (fixed by the encoding, not tunable)
  localparam int unsigned INSN_W     = 32;
  localparam int unsigned FIELD_W    = 5;
  localparam logic [5:0]  OPC_MAJOR  = 6'd31;
  localparam logic [9:0]  OPC_MINOR  = 10'd7;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_REQ  = 3'd2,
    ST_RSP  = 3'd3,
    ST_WB   = 3'd4
  } vbl_state_e;

  typedef struct packed {
    logic [5:0]         major;
    logic [FIELD_W-1:0] vd;
    logic [FIELD_W-1:0] ra;
    logic [FIELD_W-1:0] rb;
    logic [9:0]         minor;
    logic               rec;
  } vbl_word_t;

endpackage

// File: rtl/vbl_decode.sv
module vbl_decode
  import vbl_pkg::*;
(
  input  logic [INSN_W-1:0]  word,
  output logic [FIELD_W-1:0] vd,
  output logic [FIELD_W-1:0] ra,
  output logic [FIELD_W-1:0] rb,
  output logic               ra_zero,
  output logic               legal
);

  vbl_word_t f;
  logic      major_ok;
  logic      minor_ok;

  always_comb begin
    f        = vbl_word_t'(word);
    vd       = f.vd;
    ra       = f.ra;
    rb       = f.rb;
    ra_zero  = (f.ra == '0);
    major_ok = (f.major == OPC_MAJOR);
    minor_ok = (f.minor == OPC_MINOR);
    legal    = major_ok && minor_ok && !f.rec;
  end

endmodule

// File: rtl/vbl_agen.sv
module vbl_agen #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              ra_zero,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  output logic [ADDR_W-1:0] ea
);

  // Wrapping XLEN-bit sum, then keep the low ADDR_W bits. No alignment.
  function automatic logic [ADDR_W-1:0] form_ea(
    input logic            zero_base,
    input logic [XLEN-1:0] b,
    input logic [XLEN-1:0] x
  );
    logic [XLEN-1:0] eff_base;
    logic [XLEN-1:0] sum;
    eff_base = zero_base ? '0 : b;
    sum      = eff_base + x;
    return sum[ADDR_W-1:0];
  endfunction

  assign ea = form_ea(ra_zero, base_val, index_val);

endmodule

// File: rtl/vbl_lane_merge.sv
module vbl_lane_merge #(
  parameter int unsigned NBYTES = 16,
  localparam int unsigned LANE_W = $clog2(NBYTES),
  localparam int unsigned VEC_W  = 8 * NBYTES
) (
  input  logic [VEC_W-1:0]  prior,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        byte_in,
  output logic [NBYTES-1:0] lane_hit,
  output logic [VEC_W-1:0]  merged
);

  // Lane g sits at the top end: lane 0 is the most significant byte.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int unsigned LO = 8 * (NBYTES - 1 - g);
    assign lane_hit[g]    = (lane == LANE_W'(g));
    assign merged[LO +: 8] = lane_hit[g] ? byte_in : prior[LO +: 8];
  end

endmodule

// File: rtl/vbl_ctrl.sv
module vbl_ctrl
  import vbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_valid,
  input  logic       legal,
  input  logic       req_ready,
  input  logic       rsp_valid,
  output vbl_state_e state,
  output logic       insn_fire,
  output logic       req_fire,
  output logic       rsp_fire
);

  vbl_state_e nxt;

  assign insn_fire = (state == ST_IDLE) && insn_valid;
  assign req_fire  = (state == ST_REQ)  && req_ready;
  assign rsp_fire  = (state == ST_RSP)  && rsp_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (insn_valid) nxt = ST_DEC;
      ST_DEC:  nxt = legal ? ST_REQ : ST_IDLE;
      ST_REQ:  if (req_ready) nxt = ST_RSP;
      ST_RSP:  if (rsp_valid) nxt = ST_WB;
      ST_WB:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/vbyte_load_unit.sv
module vbyte_load_unit
  import vbl_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned PC_STEP   = 4,
  localparam int unsigned VEC_W     = 8 * VEC_BYTES,
  localparam int unsigned LANE_W    = $clog2(VEC_BYTES),
  localparam int unsigned PC_STEP_W = $clog2(PC_STEP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [31:0]          insn_word,
  output logic                 insn_ready,
  output logic [4:0]           gpr_a_idx,
  input  logic [XLEN-1:0]      gpr_a_data,
  output logic [4:0]           gpr_b_idx,
  input  logic [XLEN-1:0]      gpr_b_data,
  output logic [4:0]           vec_rd_idx,
  input  logic [VEC_W-1:0]     vec_rd_data,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [7:0]           mem_rsp_data,
  output logic                 vec_we,
  output logic [4:0]           vec_wr_idx,
  output logic [VEC_W-1:0]     vec_wr_data,
  output logic                 illegal,
  output logic                 done,
  output logic [PC_STEP_W-1:0] pc_step
);

  // Named internal events
  vbl_state_e          state;
  logic                insn_fire;
  logic                req_fire;
  logic                rsp_fire;
  logic                in_dec;

  logic [31:0]         word_q;
  logic [ADDR_W-1:0]   ea_q;
  logic [7:0]          byte_q;

  logic [FIELD_W-1:0]  f_vd, f_ra, f_rb;
  logic                f_ra_zero;
  logic                f_legal;
  logic [ADDR_W-1:0]   ea_comb;
  logic [VEC_BYTES-1:0] lane_hit;

  vbl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_valid(insn_valid),
    .legal     (f_legal),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .state     (state),
    .insn_fire (insn_fire),
    .req_fire  (req_fire),
    .rsp_fire  (rsp_fire)
  );

  vbl_decode u_dec (
    .word   (word_q),
    .vd     (f_vd),
    .ra     (f_ra),
    .rb     (f_rb),
    .ra_zero(f_ra_zero),
    .legal  (f_legal)
  );

  vbl_agen #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_agen (
    .ra_zero  (f_ra_zero),
    .base_val (gpr_a_data),
    .index_val(gpr_b_data),
    .ea       (ea_comb)
  );

  vbl_lane_merge #(.NBYTES(VEC_BYTES)) u_merge (
    .prior   (vec_rd_data),
    .lane    (ea_q[LANE_W-1:0]),
    .byte_in (byte_q),
    .lane_hit(lane_hit),
    .merged  (vec_wr_data)
  );

  assign in_dec = (state == ST_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ea_q   <= '0;
      byte_q <= '0;
    end else begin
      if (insn_fire)           word_q <= insn_word;
      if (in_dec && f_legal)   ea_q   <= ea_comb;
      if (rsp_fire)            byte_q <= mem_rsp_data;
    end
  end

  assign insn_ready    = (state == ST_IDLE);
  assign gpr_a_idx     = f_ra;
  assign gpr_b_idx     = f_rb;
  assign vec_rd_idx    = f_vd;
  assign vec_wr_idx    = f_vd;
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign illegal       = in_dec && !f_legal;
  assign vec_we        = (state == ST_WB);
  assign done          = vec_we;
  assign pc_step       = done ? PC_STEP_W'(PC_STEP) : '0;

endmodule

// File: rtl/vbl_checker.sv
module vbl_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned PC_STEP   = 4,
  localparam int unsigned VEC_W     = 8 * VEC_BYTES,
  localparam int unsigned LANE_W    = $clog2(VEC_BYTES),
  localparam int unsigned PC_STEP_W = $clog2(PC_STEP + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 insn_ready,
  input logic [VEC_W-1:0]     vec_rd_data,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [ADDR_W-1:0]    mem_req_addr,
  input logic                 mem_rsp_valid,
  input logic [7:0]           mem_rsp_data,
  input logic                 vec_we,
  input logic [VEC_W-1:0]     vec_wr_data,
  input logic                 illegal,
  input logic                 done,
  input logic [PC_STEP_W-1:0] pc_step
);

  logic [LANE_W-1:0] seen_lane_q;
  logic [7:0]        seen_byte_q;
  logic [VEC_W-1:0]  lane_mask;
  logic [7:0]        lane_byte;
  int unsigned       shift_amt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_lane_q <= '0;
      seen_byte_q <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) seen_lane_q <= mem_req_addr[LANE_W-1:0];
      if (mem_rsp_valid)                  seen_byte_q <= mem_rsp_data;
    end
  end

  always_comb begin
    shift_amt = 8 * (VEC_BYTES - 1 - int'(seen_lane_q));
    lane_mask = {{(VEC_W-8){1'b0}}, 8'hFF} << shift_amt;
    lane_byte = 8'(vec_wr_data >> shift_amt);
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_wr_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_we) |-> $past(mem_rsp_valid));

  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> !vec_we);

  p_done_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vec_we && (pc_step == PC_STEP_W'(PC_STEP)));

  p_lane_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |-> lane_byte == seen_byte_q);

  p_keep_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |-> ((vec_wr_data ^ vec_rd_data) & ~lane_mask) == '0);

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req_valid && !vec_we && !done);

  p_illegal_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal && insn_ready);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || vec_we) |-> !insn_ready);

endmodule

bind vbyte_load_unit vbl_checker #(
  .ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .PC_STEP(PC_STEP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_ready   (insn_ready),
  .vec_rd_data  (vec_rd_data),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data (mem_rsp_data),
  .vec_we       (vec_we),
  .vec_wr_data  (vec_wr_data),
  .illegal      (illegal),
  .done         (done),
  .pc_step      (pc_step)
);

// File: tb/vbyte_load_unit_bench.sv
`timescale 1ns/1ps
module vbyte_load_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [31:0]  insn_word = '0;
  logic         insn_ready;
  logic [4:0]   gpr_a_idx, gpr_b_idx, vec_rd_idx, vec_wr_idx;
  logic [63:0]  gpr_a_data, gpr_b_data;
  logic [127:0] vec_rd_data, vec_wr_data;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [7:0]   mem_rsp_data = '0;
  logic         vec_we, illegal, done;
  logic [2:0]   pc_step;

  logic [63:0]  gprf [32];
  logic [127:0] vrf  [32];

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign gpr_a_data  = gprf[gpr_a_idx];
  assign gpr_b_data  = gprf[gpr_b_idx];
  assign vec_rd_data = vrf[vec_rd_idx];

  vbyte_load_unit u_vbyte_load_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] maj, input logic [4:0] vd,
                                      input logic [4:0] ra, input logic [4:0] rb,
                                      input logic [9:0] mino, input logic rc);
    return {maj, vd, ra, rb, mino, rc};
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[31:24] ^ 8'h3C;
  endfunction

  // Per-cycle monitor: reference expectations that hold on every clock.
  logic        mon_prev_v = 1'b0;
  logic [31:0] mon_prev_a = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mon_prev_v && mem_req_valid)
        chk(mem_req_addr == mon_prev_a, "R5 addr steady", mem_req_addr, mon_prev_a);
      chk(!(illegal && (vec_we || mem_req_valid)), "R9 exclusive", {illegal, vec_we}, 0);
      chk(done == vec_we, "R8 done/we", done, vec_we);
      mon_prev_v <= mem_req_valid;
      mon_prev_a <= mem_req_addr;
    end
  end

  task automatic run_load(input logic [4:0] vd, input logic [4:0] ra, input logic [4:0] rb,
                          input int rdy_wait, input int rsp_wait, input bit poke_busy);
    logic [63:0]  base;
    logic [63:0]  sum;
    logic [31:0]  ea;
    int           lane;
    logic [7:0]   b;
    logic [127:0] expv;
    base = (ra == 0) ? 64'd0 : gprf[ra];
    sum  = base + gprf[rb];
    ea   = sum[31:0];
    lane = int'(ea % 16);
    b    = mem_byte(ea);
    expv = vrf[vd];
    for (int l = 0; l < 16; l++)
      if (l == lane) expv[8*(15-l) +: 8] = b;

    @(negedge clk);
    chk(insn_ready == 1'b1, "R10 idle ready", insn_ready, 1);
    insn_valid = 1'b1;
    insn_word  = enc(6'd31, vd, ra, rb, 10'd7, 1'b0);
    @(negedge clk);
    insn_valid = 1'b0;
    chk(gpr_a_idx == ra, "R2 base idx", gpr_a_idx, ra);
    chk(gpr_b_idx == rb, "R2 index idx", gpr_b_idx, rb);
    chk(illegal == 1'b0, "R1 legal word", illegal, 0);
    @(negedge clk);
    chk(mem_req_valid == 1'b1, "R4 req issued", mem_req_valid, 1);
    chk(mem_req_addr == ea, "R4 address", mem_req_addr, ea);
    for (int i = 0; i < rdy_wait; i++) begin
      if (poke_busy && i == 0) begin
        insn_valid = 1'b1;
        insn_word  = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      insn_valid = 1'b0;
      chk(insn_ready == 1'b0, "R10 busy", insn_ready, 0);
      chk(mem_req_valid && mem_req_addr == ea, "R5 held", mem_req_addr, ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0, "R5 drop", mem_req_valid, 0);
    chk(illegal == 1'b0, "R10 no decode while busy", illegal, 0);
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      chk(vec_we == 1'b0, "R8 no early write", vec_we, 0);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = b;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(vec_we == 1'b1, "R8 write", vec_we, 1);
    chk(vec_wr_idx == vd, "R2 dest idx", vec_wr_idx, vd);
    chk(vec_wr_data[8*(15-lane) +: 8] == b, "R6 lane byte", vec_wr_data, expv);
    chk(vec_wr_data == expv, "R7 other lanes", vec_wr_data, expv);
    chk(done == 1'b1 && pc_step == 3'd4, "R8 done step", {done, pc_step}, {1'b1, 3'd4});
    vrf[vd] = vec_wr_data;
    @(negedge clk);
    chk(!vec_we && !done && pc_step == 0, "R8 one pulse", {vec_we, done, pc_step}, 0);
    chk(insn_ready == 1'b1 && illegal == 1'b0, "R10 back idle", {insn_ready, illegal}, 2);
  endtask

  task automatic run_bad(input logic [31:0] w, input string why);
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = w;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(illegal == 1'b1, {"R1 reject ", why}, illegal, 1);
    chk(!mem_req_valid && !vec_we && !done, "R9 quiet", {mem_req_valid, vec_we, done}, 0);
    @(negedge clk);
    chk(illegal == 1'b0 && insn_ready == 1'b1, "R9 one cycle", {illegal, insn_ready}, 1);
    chk(mem_req_valid == 1'b0, "R9 no request", mem_req_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      gprf[i] = {32'(i * 32'h0101_0101), 32'(i * 32'h1111_0011)};
      for (int l = 0; l < 16; l++) vrf[i][8*l +: 8] = 8'(i * 16 + l + 8'h40);
    end
    gprf[0] = 64'hDEAD_BEEF_0000_0040;            // must be ignored (R3)
    gprf[4] = 64'h0000_0000_1234_5673;
    gprf[5] = 64'hFFFF_FFFF_FFFF_FFF0;
    gprf[6] = 64'h0000_0000_0000_002F;
    gprf[7] = 64'h0000_0005_8000_0000;
    gprf[8] = 64'h0000_0003_0000_0008;
    gprf[9] = 64'h0000_0000_0000_0100;
    gprf[10] = 64'h0000_0000_0000_0A00;

    repeat (3) @(negedge clk);
    chk(insn_ready == 1 && mem_req_valid == 0 && vec_we == 0 && done == 0
        && illegal == 0 && pc_step == 0, "R8 reset state",
        {insn_ready, mem_req_valid, vec_we, done, illegal}, 16);
    rst_n = 1'b1;

    run_load(5'd3, 5'd0, 5'd4, 0, 0, 1'b0);   // R3: zero base, lane 3
    run_load(5'd12, 5'd5, 5'd6, 2, 1, 1'b0);  // R4: 64-bit wrap, lane 15
    run_load(5'd20, 5'd7, 5'd8, 3, 4, 1'b1);  // R4 truncation, lane 8, R10 poke
    run_load(5'd31, 5'd9, 5'd10, 1, 0, 1'b0); // R6: lane 0
    run_load(5'd3, 5'd0, 5'd6, 0, 2, 1'b0);   // R7: same reg again, lane 15
    run_bad(enc(6'd30, 5'd1, 5'd2, 5'd3, 10'd7, 1'b0), "major");
    run_bad(enc(6'd31, 5'd1, 5'd2, 5'd3, 10'd39, 1'b0), "minor");
    run_bad(enc(6'd31, 5'd1, 5'd2, 5'd3, 10'd7, 1'b1), "record");
    run_load(5'd1, 5'd2, 5'd3, 0, 0, 1'b0);   // R1: legal after rejects

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule